// File: doc/BRIEF.md
# Marking-Compensated Clock Offset Estimator

This block sits at a time-synchronization endpoint. It turns one completed request/response exchange into a clock offset and a round-trip delay. Switches along the path may have tagged each packet with a marking count, one step for each queue threshold the packet crossed. The block turns each leg's count into a queuing delay equal to the count times a configured minimum per-threshold delay. It removes that delay from its own leg before the usual four-timestamp arithmetic. This cancels most of the offset error that uneven queuing on the two legs would otherwise cause.

An exchange enters as one valid-qualified bundle: the request departure (t1), the request arrival (t2), the response departure (t3) and the response arrival (t4), the forward and reverse marking counts, and an encoding selector. The count arrives either as a plain binary integer or as a bit-shift field in which each crossed threshold sets one more bit. The per-threshold delay comes from a configuration register held outside the block. It is read on the same edge that accepts the exchange. The result comes out three cycles later as a valid-qualified offset and delay, and a new exchange can enter on every cycle.

The block has no control state machine. Its only control is a three-stage valid pipeline made of the stages decode, compensate and combine. Each stage passes its valid bit forward on every clock edge with no stalls, so there are no named states or transitions.

Top module: `mark_offset_est`

## Requirements
- R1: While reset is low and on the first edge after it is released, `res_valid` is 0 and `res_offset` and `res_delay` are 0.
- R2: An exchange accepted with `ex_valid`=1 on a rising edge produces `res_valid`=1 right after the third rising edge from that one, and at no other time. Back-to-back exchanges produce back-to-back results in order.
- R3: With both counts zero, `res_offset` = ((t2 − t1) − (t4 − t3)) >>> 1, whatever the value of `cfg_step`.
- R4: The forward delay Df = forward count × `cfg_step` is subtracted from the forward leg (t2 − t1) only.
- R5: The reverse delay Dr = reverse count × `cfg_step` is subtracted from the reverse leg (t4 − t3) only, independently of the forward count.
- R6: With `ex_enc`=0 (integer encoding) the count equals the binary value of the count field.
- R7: With `ex_enc`=1 (bit-shift encoding) the count equals the number of set bits in the count field, so 8'b0000_0111 means 3.
- R8: `res_delay` = (t4 − t1) − (t3 − t2) − Df − Dr when that value is zero or positive, and 0 when it is negative.
- R9: The halving in the offset is an arithmetic right shift of the 65-bit difference, so it rounds toward minus infinity (a difference of −3 gives −2).
- R10: `cfg_step` is sampled on the edge that accepts the exchange. A later change does not alter a result already in the pipeline.
- R11: On cycles with `res_valid`=0, `res_offset` and `res_delay` keep the last result they showed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | Exchange bundle valid |
| ex_t1 | input | 64 | Request departure time, ns, unsigned |
| ex_t2 | input | 64 | Request arrival time, ns, unsigned |
| ex_t3 | input | 64 | Response departure time, ns, unsigned |
| ex_t4 | input | 64 | Response arrival time, ns, unsigned |
| ex_fwd_cnt | input | 8 | Forward-leg marking count field |
| ex_rev_cnt | input | 8 | Reverse-leg marking count field |
| ex_enc | input | 1 | Count encoding: 0 integer, 1 bit-shift |
| cfg_step | input | 32 | Minimum delay per crossed threshold, ns |
| res_valid | output | 1 | Result valid |
| res_offset | output | 64 | Compensated clock offset, ns, signed |
| res_delay | output | 64 | Compensated round-trip delay, ns, signed, never negative |

## Verification
Each result is due exactly three rising edges after the edge that accepts its exchange. The bench drives inputs just after a falling edge and compares outputs on falling edges. In the streaming table walk, the result of vector i is read at the falling edge three iterations after vector i was driven, so that the read lands between the third and fourth edges. Directed tests confirm that `res_valid` is still low two falling edges after a lone exchange and high on the third. They also confirm that a step value changed one cycle after acceptance does not reach that result, and that the outputs hold through idle cycles.

// File: rtl/mark_pkg.sv
package mark_pkg;
    // Encoding of the marking count field
    typedef enum logic {
        CNT_INT   = 1'b0,
        CNT_SHIFT = 1'b1
    } cnt_enc_e;

    localparam int LEGS = 2;   // leg 0 forward, leg 1 reverse
endpackage

// File: rtl/mark_cnt_decode.sv
module mark_cnt_decode
    import mark_pkg::*;
#(
    parameter int CW = 8
) (
    input  cnt_enc_e          enc,
    input  logic [CW-1:0]     raw,
    output logic [CW-1:0]     count
);
    // R6 integer form passes through, R7 bit-shift form is a population count
    always_comb begin
        count = '0;
        unique case (enc)
            CNT_INT: count = raw;
            CNT_SHIFT: begin
                for (int i = 0; i < CW; i++) begin
                    count = count + CW'(raw[i]);
                end
            end
        endcase
    end
endmodule

// File: rtl/mark_leg_comp.sv
module mark_leg_comp #(
    parameter int TW = 64,
    parameter int CW = 8,
    parameter int KW = 32
) (
    input  logic [TW-1:0]        t_send,
    input  logic [TW-1:0]        t_recv,
    input  logic [CW-1:0]        count,
    input  logic [KW-1:0]        step,
    output logic signed [TW-1:0] leg
);
    localparam int PW = CW + KW;

    logic [PW-1:0] qdelay;

    // R4 / R5: queuing delay of one leg, removed from that leg only
    assign qdelay = PW'(count) * PW'(step);
    assign leg    = signed'(t_recv - t_send - TW'(qdelay));
endmodule

// File: rtl/mark_offset_combine.sv
module mark_offset_combine #(
    parameter int TW = 64
) (
    input  logic signed [TW-1:0] fwd,
    input  logic signed [TW-1:0] rev,
    output logic signed [TW-1:0] offset,
    output logic signed [TW-1:0] delay
);
    logic signed [TW:0]   diff;
    logic signed [TW-1:0] sum;

    // R9: widened difference, halved with an arithmetic shift
    assign diff   = {fwd[TW-1], fwd} - {rev[TW-1], rev};
    assign offset = TW'(diff >>> 1);

    // R8: sum of compensated legs, clamped at zero
    assign sum    = fwd + rev;
    assign delay  = sum[TW-1] ? '0 : sum;
endmodule

// File: rtl/mark_offset_est.sv
module mark_offset_est
    import mark_pkg::*;
#(
    parameter int TW = 64,
    parameter int CW = 8,
    parameter int KW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ex_valid,
    input  logic [TW-1:0]        ex_t1,
    input  logic [TW-1:0]        ex_t2,
    input  logic [TW-1:0]        ex_t3,
    input  logic [TW-1:0]        ex_t4,
    input  logic [CW-1:0]        ex_fwd_cnt,
    input  logic [CW-1:0]        ex_rev_cnt,
    input  logic                 ex_enc,
    input  logic [KW-1:0]        cfg_step,
    output logic                 res_valid,
    output logic signed [TW-1:0] res_offset,
    output logic signed [TW-1:0] res_delay
);
    logic [TW-1:0] in_send [LEGS];
    logic [TW-1:0] in_recv [LEGS];
    logic [CW-1:0] in_raw  [LEGS];
    logic [CW-1:0] in_cnt  [LEGS];

    assign in_send[0] = ex_t1;
    assign in_recv[0] = ex_t2;
    assign in_raw[0]  = ex_fwd_cnt;
    assign in_send[1] = ex_t3;
    assign in_recv[1] = ex_t4;
    assign in_raw[1]  = ex_rev_cnt;

    // Stage 1: decode, and capture step with the exchange (R10)
    logic          s1_valid;
    logic [TW-1:0] s1_send [LEGS];
    logic [TW-1:0] s1_recv [LEGS];
    logic [CW-1:0] s1_cnt  [LEGS];
    logic [KW-1:0] s1_step;

    // Stage 2: compensated legs
    logic                 s2_valid;
    logic signed [TW-1:0] s2_leg  [LEGS];
    logic signed [TW-1:0] cmp_leg [LEGS];

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        mark_cnt_decode #(.CW(CW)) u_dec (
            .enc   (cnt_enc_e'(ex_enc)),
            .raw   (in_raw[g]),
            .count (in_cnt[g])
        );

        mark_leg_comp #(.TW(TW), .CW(CW), .KW(KW)) u_comp (
            .t_send (s1_send[g]),
            .t_recv (s1_recv[g]),
            .count  (s1_cnt[g]),
            .step   (s1_step),
            .leg    (cmp_leg[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_send[g] <= '0;
                s1_recv[g] <= '0;
                s1_cnt[g]  <= '0;
                s2_leg[g]  <= '0;
            end else begin
                if (ex_valid) begin
                    s1_send[g] <= in_send[g];
                    s1_recv[g] <= in_recv[g];
                    s1_cnt[g]  <= in_cnt[g];
                end
                if (s1_valid) begin
                    s2_leg[g] <= cmp_leg[g];
                end
            end
        end
    end

    // Stage 3: combine
    logic signed [TW-1:0] cmb_offset;
    logic signed [TW-1:0] cmb_delay;

    mark_offset_combine #(.TW(TW)) u_comb (
        .fwd    (s2_leg[0]),
        .rev    (s2_leg[1]),
        .offset (cmb_offset),
        .delay  (cmb_delay)
    );

    // Valid pipeline (R2) and result registers that hold when idle (R11, R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s2_valid   <= 1'b0;
            res_valid  <= 1'b0;
            s1_step    <= '0;
            res_offset <= '0;
            res_delay  <= '0;
        end else begin
            s1_valid  <= ex_valid;
            s2_valid  <= s1_valid;
            res_valid <= s2_valid;
            if (ex_valid) begin
                s1_step <= cfg_step;
            end
            if (s2_valid) begin
                res_offset <= cmb_offset;
                res_delay  <= cmb_delay;
            end
        end
    end
endmodule

// File: rtl/mark_offset_est_chk.sv
module mark_offset_est_chk #(
    parameter int TW = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ex_valid,
    input logic                 res_valid,
    input logic signed [TW-1:0] res_offset,
    input logic signed [TW-1:0] res_delay
);
    logic [1:0] cyc;
    logic [2:0] vhist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc   <= '0;
            vhist <= '0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
            vhist <= {vhist[1:0], ex_valid};
        end
    end

    // R1: outputs still at reset values on the first edge after release
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!res_valid && res_offset == '0 && res_delay == '0));

    // R2: result valid exactly three edges after acceptance
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (res_valid == vhist[2]));

    // R8: a presented delay is never negative
    p_delay_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !res_delay[TW-1]);

    // R11: outputs hold while no result is presented
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !res_valid) |-> ($stable(res_offset) && $stable(res_delay)));
endmodule

bind mark_offset_est mark_offset_est_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_valid   (ex_valid),
    .res_valid  (res_valid),
    .res_offset (res_offset),
    .res_delay  (res_delay)
);

// File: tb/mark_offset_est_bench.sv
module mark_offset_est_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    // Stimulus and expected results, hand-computed from R3..R9
    localparam logic [63:0] V_T1 [NV] = '{64'd1000, 64'd1000, 64'd1000, 64'd1000, 64'd1000, 64'd0,  64'd5000};
    localparam logic [63:0] V_T2 [NV] = '{64'd1600, 64'd1600, 64'd1600, 64'd1600, 64'd1600, 64'd10, 64'd4000};
    localparam logic [63:0] V_T3 [NV] = '{64'd1700, 64'd1700, 64'd1700, 64'd1700, 64'd1700, 64'd20, 64'd4100};
    localparam logic [63:0] V_T4 [NV] = '{64'd2100, 64'd2100, 64'd2100, 64'd2100, 64'd2100, 64'd33, 64'd5300};
    localparam logic [7:0]  V_FC [NV] = '{8'd0, 8'd3, 8'd0, 8'b0000_0111, 8'd8, 8'd0, 8'd0};
    localparam logic [7:0]  V_RC [NV] = '{8'd0, 8'd0, 8'd2, 8'b0000_0001, 8'd5, 8'd0, 8'd0};
    localparam logic        V_EN [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] V_K  [NV] = '{32'd100, 32'd100, 32'd100, 32'd100, 32'd100, 32'd77, 32'd9};
    localparam longint      V_OFF[NV] = '{100, -50, 200, 0, -50, -2, -1100};
    localparam longint      V_DLY[NV] = '{1000, 700, 800, 600, 0, 23, 200};
    localparam string       V_REQ[NV] = '{"R3", "R4 R6", "R5", "R7", "R8 clamp", "R9", "R3 neg"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [63:0] ex_t1 = '0, ex_t2 = '0, ex_t3 = '0, ex_t4 = '0;
    logic [7:0]  ex_fwd_cnt = '0, ex_rev_cnt = '0;
    logic        ex_enc = 1'b0;
    logic [31:0] cfg_step = '0;
    logic        res_valid;
    logic signed [63:0] res_offset, res_delay;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mark_offset_est u_mark_offset_est (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_valid   (ex_valid),
        .ex_t1      (ex_t1),
        .ex_t2      (ex_t2),
        .ex_t3      (ex_t3),
        .ex_t4      (ex_t4),
        .ex_fwd_cnt (ex_fwd_cnt),
        .ex_rev_cnt (ex_rev_cnt),
        .ex_enc     (ex_enc),
        .cfg_step   (cfg_step),
        .res_valid  (res_valid),
        .res_offset (res_offset),
        .res_delay  (res_delay)
    );

    task automatic check(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int i);
        ex_valid   = 1'b1;
        ex_t1      = V_T1[i];
        ex_t2      = V_T2[i];
        ex_t3      = V_T3[i];
        ex_t4      = V_T4[i];
        ex_fwd_cnt = V_FC[i];
        ex_rev_cnt = V_RC[i];
        ex_enc     = V_EN[i];
        cfg_step   = V_K[i];
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", longint'(res_valid), 0);
        check("R1 offset", res_offset, 0);
        check("R1 delay", res_delay, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", longint'(res_valid), 0);

        // Table walk, one exchange per cycle (R2); result i read three falling edges later
        for (int i = 0; i < NV + 3; i++) begin
            if (i >= 3) begin
                check({V_REQ[i-3], " R2 valid"}, longint'(res_valid), 1);
                check({V_REQ[i-3], " offset"}, res_offset, V_OFF[i-3]);
                check({V_REQ[i-3], " R8 delay"}, res_delay, V_DLY[i-3]);
            end
            if (i < NV) drive(i);
            else ex_valid = 1'b0;
            @(negedge clk);
        end

        // R11: idle cycles hold the last result
        ex_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 valid low", longint'(res_valid), 0);
        check("R11 offset held", res_offset, V_OFF[NV-1]);
        check("R11 delay held", res_delay, V_DLY[NV-1]);

        // R10 + R2: lone exchange, step changes one cycle after acceptance
        drive(1);
        @(negedge clk);
        ex_valid = 1'b0;
        cfg_step = 32'd1000;
        ex_fwd_cnt = 8'd9;
        @(negedge clk);
        check("R2 not yet", longint'(res_valid), 0);
        @(negedge clk);
        check("R2 on time", longint'(res_valid), 1);
        check("R10 offset", res_offset, -50);
        check("R10 delay", res_delay, 700);
        @(negedge clk);
        check("R2 single pulse", longint'(res_valid), 0);

        // R3: zero counts ignore a large step
        drive(0);
        cfg_step = 32'd4000000;
        @(negedge clk);
        ex_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 step ignored offset", res_offset, 100);
        check("R3 step ignored delay", res_delay, 1000);

        // R7: bit-shift field with scattered bits, integer view would differ
        drive(0);
        ex_enc = 1'b1;
        ex_fwd_cnt = 8'b1000_0001;
        ex_rev_cnt = 8'b0000_0000;
        cfg_step = 32'd50;
        @(negedge clk);
        ex_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 popcount offset", res_offset, 50);
        check("R7 popcount delay", res_delay, 900);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule